// File: doc/BRIEF.md
# Cascadable Eight-Line Interrupt Controller

The block collects eight interrupt lines and ranks them by fixed priority. It tells the processor, through a single request output, when a pending line outranks everything already being serviced. Software reaches it through a byte-wide port with two addresses, chosen by `a0`. After reset, an even-address command opens a configuration sequence. That sequence loads a vector base, an optional cascade word and an optional mode word. From then on, odd-address traffic reads and writes the mask.

In normal running, even-address writes serve three purposes:
- they arm a one-shot poll, so the next even read acknowledges the winning line and returns its level;
- they choose whether even reads show pending requests or in-service lines, and that choice stays in force until changed;
- they retire the most urgent in-service line (non-specific end of interrupt).

A hardware acknowledge strobe `inta` has two possible results. Either the controller places `{base, level}` on the vector output, or, as a master whose winning line feeds a slave, it drives that line number on the cascade output. If no line qualifies when the strobe arrives, the controller reports level 7 and marks nothing in service. Software detects this spurious case by reading the in-service byte and finding bit 7 clear.

Top module: `pic_cascade_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF on an odd read, `int_out` is low, and odd writes are ignored until a configuration sequence has begun.
- R2: An even write with bit 4 set starts configuration. It clears the mask, the request bits, the in-service bits, the read select (back to requests) and any armed poll. The next odd write sets the vector base from bits 7:3.
- R3: In the starting command, bit 1 set means no cascade word follows, and bit 0 clear means no mode word follows. Once the last expected word has been taken, odd writes load the mask.
- R4: Odd writes after configuration load the mask, and odd reads return it. A set bit keeps that line from raising `int_out` or winning an acknowledge.
- R5: A request bit is set only by a low-to-high change of its input. A line held high does not request again after it has been acknowledged.
- R6: Line 0 has the highest priority. `int_out` is high exactly when the controller is configured and an unmasked request has a lower index than every in-service line.
- R7: Writing 0x0C to the even address arms a poll. The next even read returns 0x80 plus the winning level and moves that line from pending to in service. If nothing qualifies, the read returns 0x00 and changes nothing. Only one read is affected.
- R8: Writing 0x0B to the even address makes even reads return the in-service byte, and writing 0x0A makes them return the request byte. The choice holds across any number of reads.
- R9: Writing 0x20 to the even address clears the lowest-index set in-service bit. Other even writes with bits 4 and 3 clear leave the in-service byte unchanged.
- R10: On an accepted `inta`, when no cascade redirect applies, `vec_en` is high and `vec` is `{base[4:0], level}`. The winning line moves from pending to in service.
- R11: On an accepted `inta` with no qualifying line, `vec` carries level 7 and the in-service byte is unchanged.
- R12: When configured as master (`cfg_master` high, cascade word present) and the winning line has its cascade-word bit set, `inta` drives `cas_en` high with `cas_id` equal to the line number, keeps `vec_en` low, and still marks the line in service.
- R13: As a slave (`cfg_master` low, cascade word present), `inta` is accepted only when `cas_in` equals bits 2:0 of the cascade word. Otherwise it produces no output and no state change.
- R14: With no cascade word configured, every `inta` is accepted and answered with a vector, whatever `cfg_master` and `cas_in` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | High: master role, low: slave role |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| a0 | input | 1 | Address select: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected address |
| irq_in | input | 8 | Interrupt lines, edge sensed |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | Hardware acknowledge strobe, one cycle |
| cas_in | input | 3 | Cascade identity presented to a slave |
| cas_en | output | 1 | Master is redirecting this acknowledge |
| cas_id | output | 3 | Slave line being redirected to |
| vec_en | output | 1 | Vector output is valid |
| vec | output | 8 | Acknowledge vector |

## Verification
A corrupted request, mask or in-service bit shows at the ports within one cycle. It changes `int_out`, and the next even read in the current read-select mode shows the wrong byte. A wrong priority pick surfaces in the low bits of the next poll result or acknowledge vector. A mis-stepped configuration sequence shows up when a later odd write fails to appear in the mask, or when the vector base comes out wrong. Because the reference model is compared against every output on every cycle, a divergence is caught in the cycle it first becomes visible, not only at the directed checks.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned PIC_LINES = 8;
  localparam int unsigned LVL_W     = $clog2(PIC_LINES);
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned BASE_W    = DATA_W - LVL_W;

  typedef logic [PIC_LINES-1:0] line_vec_t;

  typedef enum logic [2:0] {
    CFG_IDLE,
    CFG_BASE,
    CFG_CASC,
    CFG_MODE,
    CFG_READY
  } cfg_state_e;

  // Lowest set index with a found flag in the top bit.
  function automatic logic [LVL_W:0] first_set(input line_vec_t v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = PIC_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, LVL_W'(i)};
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] make_vector(input logic [BASE_W-1:0] base,
                                                    input logic [LVL_W-1:0]  lvl);
    return {base, lvl};
  endfunction
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
  import pic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              a0,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              single_mode,
  output logic [BASE_W-1:0] vec_base,
  output line_vec_t         casc_word,
  output line_vec_t         imr,
  output logic              read_isr,
  output logic              poll_armed,
  output logic              init_clear,
  output logic              eoi_cmd
);
  cfg_state_e state;
  logic       need_mode;
  logic       wr_even, wr_odd, cmd_init, cmd_sel, cmd_op, poll_read;

  assign wr_even    = wr_en & ~a0;
  assign wr_odd     = wr_en & a0;
  assign ready      = (state == CFG_READY);
  assign cmd_init   = wr_even & wdata[4];
  assign cmd_sel    = wr_even & ~wdata[4] & wdata[3] & ready;
  assign cmd_op     = wr_even & ~wdata[4] & ~wdata[3] & ready;
  assign eoi_cmd    = cmd_op & (wdata[7:5] == 3'b001);
  assign init_clear = cmd_init;
  assign poll_read  = rd_en & ~a0 & poll_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= CFG_IDLE;
      need_mode   <= 1'b0;
      single_mode <= 1'b0;
      vec_base    <= '0;
      casc_word   <= '0;
      imr         <= '1;
      read_isr    <= 1'b0;
      poll_armed  <= 1'b0;
    end else begin
      if (poll_read) poll_armed <= 1'b0;
      if (cmd_init) begin
        state       <= CFG_BASE;
        single_mode <= wdata[1];
        need_mode   <= wdata[0];
        imr         <= '0;
        casc_word   <= '0;
        read_isr    <= 1'b0;
        poll_armed  <= 1'b0;
      end else if (wr_odd) begin
        unique case (state)
          CFG_BASE: begin
            vec_base <= wdata[DATA_W-1:LVL_W];
            if (!single_mode) state <= CFG_CASC;
            else              state <= need_mode ? CFG_MODE : CFG_READY;
          end
          CFG_CASC: begin
            casc_word <= wdata;
            state     <= need_mode ? CFG_MODE : CFG_READY;
          end
          CFG_MODE:  state <= CFG_READY;
          CFG_READY: imr   <= wdata;
          default: ;
        endcase
      end else if (cmd_sel) begin
        if (wdata[1]) read_isr <= wdata[0];
        poll_armed <= wdata[2];
      end
    end
  end

  AST_INIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !a0 && wdata[4]) |=> (imr == '0) && (state == CFG_BASE)); // R2
endmodule

// File: rtl/pic_req_core.sv
module pic_req_core
  import pic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  line_vec_t        irq_in,
  input  line_vec_t        imr,
  input  logic             init_clear,
  input  logic             eoi_cmd,
  input  logic             ack_take,
  output line_vec_t        irr,
  output line_vec_t        isr,
  output logic             win_valid,
  output logic [LVL_W-1:0] win_lvl
);
  line_vec_t        irq_q, irq_rise, cand, ack_bit, eoi_bit;
  logic             c_v, s_v;
  logic [LVL_W-1:0] c_l, s_l;

  assign irq_rise = irq_in & ~irq_q;
  assign cand     = irr & ~imr;

  always_comb begin
    {c_v, c_l} = first_set(cand);
    {s_v, s_l} = first_set(isr);
    win_valid  = c_v && (!s_v || (c_l < s_l));
    win_lvl    = c_l;
    ack_bit    = (ack_take && win_valid) ? (line_vec_t'(1) << c_l) : '0;
    eoi_bit    = (eoi_cmd && s_v) ? (line_vec_t'(1) << s_l) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
      irr   <= '0;
      isr   <= '0;
    end else begin
      irq_q <= irq_in;
      if (init_clear) begin
        irr <= '0;
        isr <= '0;
      end else begin
        irr <= (irr & ~ack_bit) | irq_rise;
        isr <= (isr & ~eoi_bit) | ack_bit;
      end
    end
  end

  AST_IRR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr & ~$past(irr)) != '0) |-> ($past(irq_rise) != '0)); // R5
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && win_valid && !init_clear) |=> isr[$past(win_lvl)]); // R10
  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_cmd && !ack_take && !init_clear && (isr != '0)) |=>
      ($countones(isr) == $countones($past(isr)) - 1)); // R9
  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !win_valid && !eoi_cmd && !init_clear) |=> (isr == $past(isr))); // R11
endmodule

// File: rtl/pic_ack_path.sv
module pic_ack_path
  import pic_pkg::*;
(
  input  logic              inta,
  input  logic              cfg_master,
  input  logic              ready,
  input  logic              single_mode,
  input  line_vec_t         casc_word,
  input  logic [BASE_W-1:0] vec_base,
  input  logic [LVL_W-1:0]  cas_in,
  input  logic              win_valid,
  input  logic [LVL_W-1:0]  win_lvl,
  output logic              inta_take,
  output logic              vec_en,
  output logic [DATA_W-1:0] vec,
  output logic              cas_en,
  output logic [LVL_W-1:0]  cas_id
);
  logic selected, redirect;

  assign selected  = single_mode | cfg_master | (cas_in == casc_word[LVL_W-1:0]);
  assign inta_take = inta & ready & selected;
  assign redirect  = cfg_master & ~single_mode & win_valid & casc_word[win_lvl];
  assign cas_en    = inta_take & redirect;
  assign cas_id    = cas_en ? win_lvl : '0;
  assign vec_en    = inta_take & ~redirect;
  assign vec       = vec_en ? make_vector(vec_base, win_valid ? win_lvl : LVL_W'(PIC_LINES - 1))
                            : '0;
endmodule

// File: rtl/pic_cascade_ctrl.sv
module pic_cascade_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_master,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       a0,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  input  logic [2:0] cas_in,
  output logic       cas_en,
  output logic [2:0] cas_id,
  output logic       vec_en,
  output logic [7:0] vec
);
  logic              ready, single_mode, read_isr, poll_armed, init_clear, eoi_cmd;
  logic [BASE_W-1:0] vec_base;
  line_vec_t         casc_word, imr, irr, isr;
  logic              win_valid, inta_take, poll_take, ack_take;
  logic [LVL_W-1:0]  win_lvl;
  logic [DATA_W-1:0] poll_byte;

  pic_cfg_regs i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0), .wdata(wdata),
    .ready(ready), .single_mode(single_mode), .vec_base(vec_base), .casc_word(casc_word),
    .imr(imr), .read_isr(read_isr), .poll_armed(poll_armed), .init_clear(init_clear),
    .eoi_cmd(eoi_cmd)
  );

  pic_req_core i_core (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .imr(imr), .init_clear(init_clear),
    .eoi_cmd(eoi_cmd), .ack_take(ack_take), .irr(irr), .isr(isr),
    .win_valid(win_valid), .win_lvl(win_lvl)
  );

  pic_ack_path i_ack (
    .inta(inta), .cfg_master(cfg_master), .ready(ready), .single_mode(single_mode),
    .casc_word(casc_word), .vec_base(vec_base), .cas_in(cas_in), .win_valid(win_valid),
    .win_lvl(win_lvl), .inta_take(inta_take), .vec_en(vec_en), .vec(vec),
    .cas_en(cas_en), .cas_id(cas_id)
  );

  assign poll_take = rd_en & ~a0 & poll_armed;
  assign ack_take  = poll_take | inta_take;
  assign int_out   = ready & win_valid;
  assign poll_byte = win_valid ? {1'b1, {(DATA_W-LVL_W-1){1'b0}}, win_lvl} : '0;

  always_comb begin
    if (a0)              rdata = imr;
    else if (poll_armed) rdata = poll_byte;
    else if (read_isr)   rdata = isr;
    else                 rdata = irr;
  end

  AST_INT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~imr) != '0)); // R6
  AST_POLL_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !(wr_en && !a0)) |=> !poll_armed); // R7
  AST_VEC_ONLY_ON_INTA: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_en || cas_en) |-> (inta && ready)); // R10
  AST_REDIRECT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_en && cas_en)); // R12
endmodule

// File: tb/test_pic_cascade_ctrl.sv
module test_pic_cascade_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0, cfg_master = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0, inta = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0;
  logic [2:0] cas_in = '0;
  logic [7:0] rdata, vec;
  logic       int_out, cas_en, vec_en;
  logic [2:0] cas_id;

  int compared = 0, mismatched = 0;
  bit done = 0;

  // behavioural reference state
  int       m_stage;
  bit [7:0] m_imr, m_irr, m_isr, m_prev, m_casw;
  bit [4:0] m_base;
  bit       m_single, m_ic4, m_rdisr, m_poll;

  always #(CLK_P/2) clk = ~clk;

  pic_cascade_ctrl i_pic_cascade_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .wr_en(wr_en), .rd_en(rd_en),
    .a0(a0), .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .int_out(int_out),
    .inta(inta), .cas_in(cas_in), .cas_en(cas_en), .cas_id(cas_id),
    .vec_en(vec_en), .vec(vec)
  );

  function automatic int lowest(bit [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction

  function automatic int m_pick();
    int b, t;
    b = lowest(m_irr & ~m_imr);
    t = lowest(m_isr);
    return (b < 8 && b < t) ? b : -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int w, t;
    bit rdy, ptake, itake, eoi;
    bit [7:0] rise;
    if (!rst_n) begin
      m_stage = 0; m_imr = 8'hFF; m_irr = 0; m_isr = 0; m_prev = 0; m_casw = 0;
      m_base = 0; m_single = 0; m_ic4 = 0; m_rdisr = 0; m_poll = 0;
    end else begin
      w = m_pick();
      t = lowest(m_isr);
      rdy = (m_stage == 4);
      ptake = rd_en && !a0 && m_poll;
      itake = inta && rdy && (m_single || cfg_master || cas_in == m_casw[2:0]);
      eoi = wr_en && !a0 && !wdata[4] && !wdata[3] && rdy && (wdata[7:5] == 3'd1);
      rise = irq_in & ~m_prev;
      m_prev = irq_in;
      if (ptake) m_poll = 0;
      if (wr_en && !a0 && wdata[4]) begin
        m_stage = 1; m_single = wdata[1]; m_ic4 = wdata[0];
        m_imr = 0; m_casw = 0; m_rdisr = 0; m_poll = 0; m_irr = 0; m_isr = 0;
      end else begin
        if ((ptake || itake) && w >= 0) begin m_irr[w] = 0; m_isr[w] = 1; end
        if (eoi && t < 8) m_isr[t] = 0;
        m_irr |= rise;
        if (wr_en && a0) begin
          case (m_stage)
            1: begin m_base = wdata[7:3]; m_stage = !m_single ? 2 : (m_ic4 ? 3 : 4); end
            2: begin m_casw = wdata; m_stage = m_ic4 ? 3 : 4; end
            3: m_stage = 4;
            4: m_imr = wdata;
            default: ;
          endcase
        end else if (wr_en && !a0 && rdy && wdata[3]) begin
          if (wdata[1]) m_rdisr = wdata[0];
          m_poll = wdata[2];
        end
      end
    end
  end

  task automatic cmp(string tag, logic [7:0] act, logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic compare_now();
    int w;
    bit sel, redir;
    bit [7:0] e_rd, e_vec;
    bit [2:0] e_id;
    w = m_pick();
    if (a0) e_rd = m_imr;
    else if (m_poll) e_rd = (w >= 0) ? (8'h80 | 8'(w)) : 8'h00;
    else e_rd = m_rdisr ? m_isr : m_irr;
    sel = (m_stage == 4) && inta && (m_single || cfg_master || cas_in == m_casw[2:0]);
    redir = cfg_master && !m_single && (w >= 0) && m_casw[w];
    e_id = (sel && redir) ? 3'(w) : 3'd0;
    e_vec = (sel && !redir) ? {m_base, (w >= 0) ? 3'(w) : 3'd7} : 8'h00;
    cmp("R6 cycle int_out", {7'd0, int_out}, {7'd0, (m_stage == 4) && (w >= 0)});
    cmp("R8 cycle rdata", rdata, e_rd);
    cmp("R10 cycle vec_en", {7'd0, vec_en}, {7'd0, sel && !redir});
    cmp("R10 cycle vec", vec, e_vec);
    cmp("R12 cycle cas_en", {7'd0, cas_en}, {7'd0, sel && redir});
    cmp("R12 cycle cas_id", {5'd0, cas_id}, {5'd0, e_id});
  endtask

  always begin
    @(negedge clk);
    #(CLK_P/4);
    if (rst_n && !done) compare_now();
  end

  task automatic wr(bit adr, bit [7:0] d);
    @(negedge clk); wr_en = 1; a0 = adr; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 0;
  endtask

  task automatic rd(bit adr, output logic [7:0] d);
    @(negedge clk); rd_en = 1; a0 = adr;
    #(CLK_P/4); d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic ack(output logic ven, output logic [7:0] v, output logic cen,
                     output logic [2:0] cid);
    @(negedge clk); inta = 1;
    #(CLK_P/4); ven = vec_en; v = vec; cen = cas_en; cid = cas_id;
    @(negedge clk); inta = 0;
  endtask

  task automatic peek_int(output logic i);
    @(negedge clk); #(CLK_P/4); i = int_out;
  endtask

  task automatic set_irq(bit [7:0] v);
    @(negedge clk); irq_in = v;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; compared++; mismatched++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, v;
    logic i, ven, cen;
    logic [2:0] cid;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state and pre-configuration writes
    rd(1, d); cmp("R1 mask after reset", d, 8'hFF);
    peek_int(i); cmp("R1 int after reset", {7'd0, i}, 8'h00);
    wr(1, 8'h00); rd(1, d); cmp("R1 odd write before config ignored", d, 8'hFF);
    // R2 master configuration: base 0x20, slave on line 2, mode word
    wr(0, 8'h11); rd(1, d); cmp("R2 start clears mask", d, 8'h00);
    wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
    wr(1, 8'hFF); rd(1, d); cmp("R4 mask readback", d, 8'hFF);
    // R4/R5 masked edge is recorded but silent
    set_irq(8'h08);
    peek_int(i); cmp("R4 masked line no int", {7'd0, i}, 8'h00);
    rd(0, d); cmp("R5 edge sets request bit", d, 8'h08);
    wr(1, 8'hF7);
    peek_int(i); cmp("R6 unmasked request raises int", {7'd0, i}, 8'h01);
    // R10 hardware acknowledge
    ack(ven, v, cen, cid);
    cmp("R10 vector", v, 8'h23); cmp("R10 vec_en", {7'd0, ven}, 8'h01);
    wr(0, 8'h0B); rd(0, d); cmp("R8 in-service after ack", d, 8'h08);
    wr(0, 8'h0A); rd(0, d); cmp("R5 held line does not re-request", d, 8'h00);
    // R6/R7 priority and poll
    wr(1, 8'h00);
    set_irq(8'h2A);
    wr(0, 8'h0C); rd(0, d); cmp("R7 poll returns line 1", d, 8'h81);
    wr(0, 8'h0B); rd(0, d); cmp("R7 poll marks in service", d, 8'h0A);
    peek_int(i); cmp("R6 lower line blocked by in-service", {7'd0, i}, 8'h00);
    // R9 end of interrupt
    wr(0, 8'h20); rd(0, d); cmp("R9 eoi clears line 1 / R8 persists", d, 8'h08);
    peek_int(i); cmp("R6 line 5 still below line 3", {7'd0, i}, 8'h00);
    wr(0, 8'h20);
    peek_int(i); cmp("R6 int after all retired", {7'd0, i}, 8'h01);
    ack(ven, v, cen, cid); cmp("R10 vector line 5", v, 8'h25);
    wr(0, 8'h60); rd(0, d); cmp("R9 other command ignored", d, 8'h20);
    wr(0, 8'h20); rd(0, d); cmp("R9 eoi clears line 5", d, 8'h00);
    wr(0, 8'h0C); rd(0, d); cmp("R7 empty poll", d, 8'h00);
    wr(0, 8'h0A); rd(0, d); cmp("R7 empty poll changed nothing", d, 8'h00);
    // R11 spurious acknowledge
    wr(1, 8'hFF);
    ack(ven, v, cen, cid);
    cmp("R11 spurious vector", v, 8'h27); cmp("R11 spurious vec_en", {7'd0, ven}, 8'h01);
    wr(0, 8'h0B); rd(0, d); cmp("R11 in-service bit 7 clear", d, 8'h00);
    // R12 master redirect on line 2
    wr(1, 8'h00);
    set_irq(8'h2E);
    ack(ven, v, cen, cid);
    cmp("R12 cas_en", {7'd0, cen}, 8'h01); cmp("R12 cas_id", {5'd0, cid}, 8'h02);
    cmp("R12 no vector", {7'd0, ven}, 8'h00);
    rd(0, d); cmp("R12 redirected line in service", d, 8'h04);
    // R3/R14 single mode, no mode word
    set_irq(8'h00);
    wr(0, 8'h12); wr(1, 8'h40); wr(1, 8'hAA);
    rd(1, d); cmp("R3 words skipped, mask loaded", d, 8'hAA);
    cfg_master = 0; cas_in = 3'd5;
    set_irq(8'h01);
    ack(ven, v, cen, cid);
    cmp("R14 single answers any inta", v, 8'h40);
    cmp("R14 no redirect", {7'd0, cen}, 8'h00);
    // R13 slave with identity 2
    set_irq(8'h00);
    wr(0, 8'h11); wr(1, 8'h08); wr(1, 8'h02); wr(1, 8'h01); wr(1, 8'h00);
    set_irq(8'h10);
    peek_int(i); cmp("R13 slave int", {7'd0, i}, 8'h01);
    cas_in = 3'd3;
    ack(ven, v, cen, cid);
    cmp("R13 wrong id no vector", {7'd0, ven}, 8'h00);
    wr(0, 8'h0B); rd(0, d); cmp("R13 wrong id no state change", d, 8'h00);
    cas_in = 3'd2;
    ack(ven, v, cen, cid); cmp("R13 matching id vector", v, 8'h0C);
    rd(0, d); cmp("R13 matching id in service", d, 8'h10);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule